// File: doc/BRIEF.md
# Hardware A20 Gate Sequencer

This block watches the writes a host processor makes to a slave controller's interface. In hardware, with no firmware involved, it carries out the "write output port" command sequence that steers the A20 address gate. A command byte of D1h arms it. The data byte that follows then sets or clears the A20 output from a single bit of that byte. While it does this, the block tells the host interface which writes belong to the sequence, so that the input-buffer-full flag is not raised for them and the CPU never sees these bytes.

The CPU switches the feature on with a one-cycle enable pulse. After that the feature stays on until reset, and nothing can switch it off. Until the pulse arrives, the block is transparent: it suppresses nothing and does not drive the A20 pin. A host write arrives as a one-cycle strobe together with its address bit and data byte. Host writes cannot be stalled, so this interface has no ready signal and no back-pressure. Every strobe is taken in the cycle it is presented. The suppress output is combinational, so the host interface can act on it in that same cycle.

Top module: `a20_gate_seq`

## Requirements
- R1: One cycle after `gate_en_pulse` is high, `a20_oe` is 1. It stays 1 until reset, whatever is written or pulsed after that.
- R2: `a20_out` changes only in the cycle after a data write (`host_a0`=0) made while the sequencer is armed.
- R3: While enabled, a command write (`host_a0`=1) of D1h raises `ibf_suppress` in the same cycle and arms the sequencer.
- R4: A data write while armed raises `ibf_suppress`. From the next cycle, `a20_out` equals bit 1 of the data byte (DFh gives 1, DDh gives 0). The sequencer then disarms.
- R5: A D1h command while already armed raises `ibf_suppress` and keeps the sequencer armed, so the next data byte is still applied.
- R6: An FFh command raises `ibf_suppress` only when it directly follows the data byte of a completed sequence. An FFh command at any other point (idle, while armed, after a stray data byte, or as a second FFh) leaves it low.
- R7: While armed, a command other than D1h or FFh cancels the sequence without suppression. The next data write is then not suppressed and leaves `a20_out` unchanged.
- R8: While not enabled, `ibf_suppress` stays 0, `a20_oe` stays 0 and `a20_out` stays 0, even for a D1h command followed by data.
- R9: Reset clears the enable, disarms the sequencer and returns `a20_out` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gate_en_pulse | input | 1 | One-cycle enable request from the CPU |
| host_wr | input | 1 | One-cycle host write strobe |
| host_a0 | input | 1 | Write type: 1 = command, 0 = data |
| host_din | input | 8 | Host write data byte |
| a20_out | output | 1 | A20 gate level |
| a20_oe | output | 1 | A20 pin driven by this block (feature enabled) |
| ibf_suppress | output | 1 | This write must not raise the input-buffer-full flag |

## Verification
The embedded assertions check on every cycle that the enable never drops once set, that A20 holds its level except on an armed data write, and that an armed data write copies the gate bit. They also check that a D1h command is always suppressed while enabled and that nothing is suppressed while disabled. Which FFh commands are suppressed depends on the history of writes before them. Double-arm, cancel, stray-data and post-reset cases therefore need whole write sequences, and the bench's scenarios cover them by comparing each write's suppress flag and the resulting A20 level against a scoreboard.

// File: rtl/a20_gate_pkg.sv
package a20_gate_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_ARMED  = 2'd1,
    SEQ_CLOSED = 2'd2
  } seq_state_t;

  // Classification of one host write strobe
  typedef struct packed {
    logic arm;     // command equal to the arming code
    logic fin;     // command equal to the closing code
    logic other;   // any other command
    logic data;    // data write
  } wr_class_t;

endpackage

// File: rtl/a20_enable_ctl.sv
module a20_enable_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic en_pulse,
  output logic en_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)        en_q <= 1'b0;
    else if (en_pulse) en_q <= 1'b1;
  end

  AST_ENABLE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> en_q); // R1

  AST_ENABLE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    en_pulse |=> en_q); // R1

endmodule

// File: rtl/a20_cmd_classify.sv
module a20_cmd_classify
  import a20_gate_pkg::*;
#(
  parameter int          DATA_W  = 8,
  parameter logic [7:0]  ARM_CMD = 8'hD1,
  parameter logic [7:0]  FIN_CMD = 8'hFF
) (
  input  logic              wr,
  input  logic              a0,
  input  logic [DATA_W-1:0] din,
  output wr_class_t         cls
);

  localparam logic [DATA_W-1:0] ARM_CODE = DATA_W'(ARM_CMD);
  localparam logic [DATA_W-1:0] FIN_CODE = DATA_W'(FIN_CMD);

  logic is_cmd;
  logic hit_arm;
  logic hit_fin;

  always_comb begin
    is_cmd    = wr && a0;
    hit_arm   = (din == ARM_CODE);
    hit_fin   = (din == FIN_CODE);
    cls.arm   = is_cmd && hit_arm;
    cls.fin   = is_cmd && hit_fin && !hit_arm;
    cls.other = is_cmd && !hit_arm && !hit_fin;
    cls.data  = wr && !a0;
  end

endmodule

// File: rtl/a20_seq_fsm.sv
module a20_seq_fsm
  import a20_gate_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en_q,
  input  wr_class_t cls,
  output logic      apply,
  output logic      ibf_suppress
);

  seq_state_t state_q;
  seq_state_t state_d;

  always_comb begin
    state_d = state_q;
    if (!en_q) begin
      state_d = SEQ_IDLE;
    end else begin
      unique case (state_q)
        SEQ_IDLE: begin
          if (cls.arm) state_d = SEQ_ARMED;
        end
        SEQ_ARMED: begin
          if (cls.arm)                   state_d = SEQ_ARMED;
          else if (cls.data)             state_d = SEQ_CLOSED;
          else if (cls.other || cls.fin) state_d = SEQ_IDLE;
        end
        SEQ_CLOSED: begin
          if (cls.arm)                              state_d = SEQ_ARMED;
          else if (cls.data || cls.other || cls.fin) state_d = SEQ_IDLE;
        end
        default: state_d = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= SEQ_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    apply        = en_q && (state_q == SEQ_ARMED) && cls.data;
    ibf_suppress = en_q && (cls.arm || apply ||
                            ((state_q == SEQ_CLOSED) && cls.fin));
  end

  AST_ARM_SUPPRESSED: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && cls.arm) |-> ibf_suppress); // R3

  AST_ARM_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && cls.arm) |=> (state_q == SEQ_ARMED)); // R5

  AST_CANCEL_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_ARMED && cls.other) |=> (state_q == SEQ_IDLE)); // R7

  AST_OFF_NO_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !ibf_suppress); // R8

  AST_OTHER_NEVER_SUPPRESSED: assert property (@(posedge clk) disable iff (!rst_n)
    cls.other |-> !ibf_suppress); // R7

endmodule

// File: rtl/a20_gate_reg.sv
module a20_gate_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic apply,
  input  logic gate_bit,
  output logic a20_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)     a20_q <= 1'b0;
    else if (apply) a20_q <= gate_bit;
  end

  AST_A20_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !apply |=> $stable(a20_q)); // R2

  AST_A20_COPIES_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    apply |=> (a20_q == $past(gate_bit))); // R4

endmodule

// File: rtl/a20_gate_seq.sv
module a20_gate_seq
  import a20_gate_pkg::*;
#(
  parameter int         DATA_W   = 8,
  parameter int         GATE_BIT = 1,
  parameter logic [7:0] ARM_CMD  = 8'hD1,
  parameter logic [7:0] FIN_CMD  = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gate_en_pulse,
  input  logic              host_wr,
  input  logic              host_a0,
  input  logic [DATA_W-1:0] host_din,
  output logic              a20_out,
  output logic              a20_oe,
  output logic              ibf_suppress
);

  localparam int GATE_IDX = (GATE_BIT < DATA_W) ? GATE_BIT : 0;

  logic      en_q;
  logic      apply;
  wr_class_t cls;

  a20_enable_ctl u_enable (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_pulse (gate_en_pulse),
    .en_q     (en_q)
  );

  a20_cmd_classify #(
    .DATA_W  (DATA_W),
    .ARM_CMD (ARM_CMD),
    .FIN_CMD (FIN_CMD)
  ) u_classify (
    .wr  (host_wr),
    .a0  (host_a0),
    .din (host_din),
    .cls (cls)
  );

  a20_seq_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .en_q         (en_q),
    .cls          (cls),
    .apply        (apply),
    .ibf_suppress (ibf_suppress)
  );

  a20_gate_reg u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .apply    (apply),
    .gate_bit (host_din[GATE_IDX]),
    .a20_q    (a20_out)
  );

  assign a20_oe = en_q;

  AST_OFF_A20_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !a20_oe |-> !a20_out); // R8

endmodule

// File: tb/a20_gate_seq_test.sv
module a20_gate_seq_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       gate_en_pulse = 1'b0;
  logic       host_wr = 1'b0;
  logic       host_a0 = 1'b0;
  logic [7:0] host_din = 8'h00;
  logic       a20_out;
  logic       a20_oe;
  logic       ibf_suppress;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic  exp_sup_q[$];
  logic  exp_a20_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  a20_gate_seq uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .gate_en_pulse (gate_en_pulse),
    .host_wr       (host_wr),
    .host_a0       (host_a0),
    .host_din      (host_din),
    .a20_out       (a20_out),
    .a20_oe        (a20_oe),
    .ibf_suppress  (ibf_suppress)
  );

  task automatic check1(input string tag, input string what,
                        input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  // Driver: one write strobe, expectations pushed to the scoreboard
  task automatic host_write(input logic a0, input logic [7:0] d,
                            input logic exp_sup, input logic exp_a20,
                            input string tag);
    @(negedge clk);
    host_wr  = 1'b1;
    host_a0  = a0;
    host_din = d;
    exp_sup_q.push_back(exp_sup);
    exp_a20_q.push_back(exp_a20);
    tag_q.push_back(tag);
    @(negedge clk);
    host_wr  = 1'b0;
    host_din = 8'h00;
    @(negedge clk);
  endtask

  task automatic pulse_enable();
    @(negedge clk);
    gate_en_pulse = 1'b1;
    @(negedge clk);
    gate_en_pulse = 1'b0;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  // Monitor: suppress in the strobe cycle, A20 after the following edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (host_wr && rst_n) begin
        logic  sup_seen;
        logic  es;
        logic  ea;
        string t;
        sup_seen = ibf_suppress;
        @(negedge clk);
        #1;
        if (exp_sup_q.size() == 0) begin
          checks++;
          errors++;
          $display("FAIL scoreboard: unexpected write, actual=1 expected=0");
        end else begin
          es = exp_sup_q.pop_front();
          ea = exp_a20_q.pop_front();
          t  = tag_q.pop_front();
          check1(t, "ibf_suppress", sup_seen, es);
          check1(t, "a20_out", a20_out, ea);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check1("R9", "reset a20_out", a20_out, 1'b0);
    check1("R9", "reset a20_oe", a20_oe, 1'b0);
    check1("R9", "reset suppress", ibf_suppress, 1'b0);
    rst_n = 1'b1;

    // Disabled: everything passes through
    host_write(1'b1, 8'hD1, 1'b0, 1'b0, "R8");
    host_write(1'b0, 8'hDF, 1'b0, 1'b0, "R8");
    check1("R8", "a20_oe while off", a20_oe, 1'b0);

    pulse_enable();
    check1("R1", "a20_oe after pulse", a20_oe, 1'b1);

    // Set sequence
    host_write(1'b1, 8'hD1, 1'b1, 1'b0, "R3");
    host_write(1'b0, 8'hDF, 1'b1, 1'b1, "R4");
    host_write(1'b1, 8'hFF, 1'b1, 1'b1, "R6");
    host_write(1'b1, 8'hFF, 1'b0, 1'b1, "R6");
    host_write(1'b0, 8'h55, 1'b0, 1'b1, "R2");

    // Clear sequence
    host_write(1'b1, 8'hD1, 1'b1, 1'b1, "R3");
    host_write(1'b0, 8'hDD, 1'b1, 1'b0, "R4");
    host_write(1'b1, 8'hFF, 1'b1, 1'b0, "R6");

    // Double arm
    host_write(1'b1, 8'hD1, 1'b1, 1'b0, "R5");
    host_write(1'b1, 8'hD1, 1'b1, 1'b0, "R5");
    host_write(1'b0, 8'hDF, 1'b1, 1'b1, "R5");
    host_write(1'b1, 8'hFF, 1'b1, 1'b1, "R6");

    // Cancelled by another command
    host_write(1'b1, 8'hD1, 1'b1, 1'b1, "R3");
    host_write(1'b1, 8'hAB, 1'b0, 1'b1, "R7");
    host_write(1'b0, 8'hDD, 1'b0, 1'b1, "R7");

    // FFh while armed is not a sequence end
    host_write(1'b1, 8'hD1, 1'b1, 1'b1, "R3");
    host_write(1'b1, 8'hFF, 1'b0, 1'b1, "R6");
    host_write(1'b0, 8'hDD, 1'b0, 1'b1, "R2");

    // Stray data after a completed sequence breaks the FFh window
    host_write(1'b1, 8'hD1, 1'b1, 1'b1, "R3");
    host_write(1'b0, 8'hDD, 1'b1, 1'b0, "R4");
    host_write(1'b0, 8'h02, 1'b0, 1'b0, "R2");
    host_write(1'b1, 8'hFF, 1'b0, 1'b0, "R6");

    // Enable is sticky and pulsing again changes nothing
    pulse_enable();
    check1("R1", "a20_oe still on", a20_oe, 1'b1);
    host_write(1'b1, 8'hD1, 1'b1, 1'b0, "R3");
    host_write(1'b0, 8'hFE, 1'b1, 1'b1, "R4");

    // Reset mid-run
    do_reset();
    check1("R9", "a20_out after reset", a20_out, 1'b0);
    check1("R9", "a20_oe after reset", a20_oe, 1'b0);
    host_write(1'b1, 8'hD1, 1'b0, 1'b0, "R8");
    host_write(1'b0, 8'hDF, 1'b0, 1'b0, "R8");

    repeat (3) @(negedge clk);
    checks++;
    if (exp_sup_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: pending items actual=%0d expected=0", exp_sup_q.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule